// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block holds the pending-request, in-service and mask state for eight interrupt lines. It decides whether the processor should be interrupted, and which line wins. Each line latches its request either on a rising edge or as a level, chosen per line by a trigger-mode vector. The winner is the most urgent unmasked request, where urgency is counted from a programmable rotation base and wraps around the eight lines. That winner only raises the interrupt output when it is strictly more urgent than the most urgent line already in service.

A surrounding register decoder drives the control pins. A mask write loads the mask register. An acknowledge strobe grants the current winner. Specific and non-specific end-of-interrupt strobes retire in-service lines. A rotation write loads the base directly. Auto end-of-interrupt can retire a line at the moment it is granted, and can optionally rotate the base past it. When the block serves as the master in a cascade, a nested-mode flag stops the in-service bit of the cascade line from blocking further requests. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `prio_irq_resolver`

## Requirements
- R1: A line whose trig_level bit is 1 (level mode) has its request bit equal, after each clock edge, to the input value sampled at that edge. Acknowledge never clears it.
- R2: A line whose trig_level bit is 0 (edge mode) sets its request bit only when the input is sampled high after having been sampled low at the previous edge. A falling input leaves the request bit unchanged. A rising edge in the same cycle as a grant of that line leaves the bit set.
- R3: Urgency rank r of line k is (k - offset_q) mod 8, so rank 0 is the most urgent line. int_line reports the line of the lowest-ranked request that is set and unmasked, which is (r + offset_q) mod 8.
- R4: int_pending is 1 only when that request rank is strictly lower than the lowest rank among the in-service bits. An equal rank gives 0, and no unmasked request gives 0.
- R5: When sfnm_en is 1, in-service bit 2 is left out of the in-service rank used by R4.
- R6: ack while int_pending is 1 sets isr_q[int_line] (unless auto-EOI is on), and clears irr_q[int_line] only for an edge-mode line. ack while int_pending is 0 changes nothing.
- R7: With aeoi_en at 1, a grant leaves isr_q unchanged. If rot_aeoi_en is also 1, offset_q becomes (int_line + 1) mod 8.
- R8: eoi_spec clears isr_q[eoi_line]. eoi_nonspec clears the lowest-ranked in-service bit, with bit 2 included. A grant setting the same bit wins over a clear. rot_we loads offset_q from rot_wdata, and this overrides the R7 rotation.
- R9: mask_we loads imr_q from mask_wdata at the clock edge. From the next cycle on, a masked line neither wins nor raises int_pending.
- R10: Reset clears the request, previous-level, in-service and mask registers and the rotation offset, so all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line trigger mode: 1 level, 0 edge |
| mask_we | input | 1 | Load mask register |
| mask_wdata | input | 8 | New mask value, 1 masks a line |
| sfnm_en | input | 1 | Nested mode: ignore in-service bit 2 |
| aeoi_en | input | 1 | Auto end-of-interrupt at grant |
| rot_aeoi_en | input | 1 | Rotate base after an auto-EOI grant |
| ack | input | 1 | Acknowledge strobe |
| eoi_spec | input | 1 | Clear the in-service bit named by eoi_line |
| eoi_line | input | 3 | Line for the specific clear |
| eoi_nonspec | input | 1 | Clear the most urgent in-service bit |
| rot_we | input | 1 | Load rotation base |
| rot_wdata | input | 3 | New rotation base |
| int_pending | output | 1 | A request beats everything in service |
| int_line | output | 3 | Winning line number |
| irr_q | output | 8 | Request register |
| isr_q | output | 8 | In-service register |
| imr_q | output | 8 | Mask register |
| offset_q | output | 3 | Rotation base |

## Verification
Every input acts at the next rising edge. The registers therefore show the effect of a stimulus one clock edge later. int_pending and int_line are decoded without a register from that state, so they change in the same cycle as the registers they depend on. The bench drives inputs on the falling edge, lets one rising edge pass, and compares all outputs on the following falling edge against a model advanced by exactly one step. An input change and the request it produces are therefore always checked one cycle apart.

// File: rtl/pic_res_pkg.sv
package pic_res_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture
  import pic_res_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] trig_level,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr_q,
  output logic [N-1:0] prev_q
);
  logic [N-1:0] irr_next;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_comb begin
      if (trig_e'(trig_level[g]) == TRIG_LEVEL)
        irr_next[g] = irq_in[g];
      else
        irr_next[g] = (irr_q[g] & ~ack_clr[g]) | (irq_in[g] & ~prev_q[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      prev_q <= '0;
    end else begin
      irr_q  <= irr_next;
      prev_q <= irq_in;
    end
  end

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((irr_q ^ $past(irq_in)) & $past(trig_level)) == '0)); // R1
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_in & ~prev_q & ~trig_level) & ~irr_q) == '0)); // R2
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irr_q & ~trig_level & ~ack_clr) & ~irr_q) == '0)); // R2
endmodule

// File: rtl/pic_prio_scan.sv
module pic_prio_scan #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic [IW:0]   rel
);
  always_comb begin
    rel = (IW+1)'(N);
    for (int i = N - 1; i >= 0; i--) begin
      logic [IW-1:0] idx;
      idx = base + IW'(i);
      if (vec[idx]) rel = (IW+1)'(i);
    end
  end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver #(
  parameter int N         = 8,
  parameter int CASC_LINE = 2,
  localparam int IW       = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  trig_level,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_wdata,
  input  logic          sfnm_en,
  input  logic          aeoi_en,
  input  logic          rot_aeoi_en,
  input  logic          ack,
  input  logic          eoi_spec,
  input  logic [IW-1:0] eoi_line,
  input  logic          eoi_nonspec,
  input  logic          rot_we,
  input  logic [IW-1:0] rot_wdata,
  output logic          int_pending,
  output logic [IW-1:0] int_line,
  output logic [N-1:0]  irr_q,
  output logic [N-1:0]  isr_q,
  output logic [N-1:0]  imr_q,
  output logic [IW-1:0] offset_q
);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC_LINE;
  localparam logic [IW:0]  EMPTY    = (IW+1)'(N);

  logic [N-1:0] prev_q;
  logic [N-1:0] req_vec, isr_eff, grant_mask, ack_clr, isr_set, isr_clr;
  logic [IW:0]  req_rel, cur_rel, isr_rel;
  logic         grant;

  pic_req_capture #(.N(N)) u_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_level),
    .ack_clr(ack_clr), .irr_q(irr_q), .prev_q(prev_q)
  );

  assign req_vec = irr_q & ~imr_q;
  assign isr_eff = sfnm_en ? (isr_q & ~CASC_BIT) : isr_q;

  pic_prio_scan #(.N(N)) u_scan_req (.vec(req_vec), .base(offset_q), .rel(req_rel));
  pic_prio_scan #(.N(N)) u_scan_cur (.vec(isr_eff), .base(offset_q), .rel(cur_rel));
  pic_prio_scan #(.N(N)) u_scan_isr (.vec(isr_q),   .base(offset_q), .rel(isr_rel));

  assign int_pending = req_rel < cur_rel;
  assign int_line    = req_rel[IW-1:0] + offset_q;
  assign grant       = ack && int_pending;
  assign grant_mask  = grant ? (N'(1) << int_line) : '0;
  assign ack_clr     = grant_mask & ~trig_level;
  assign isr_set     = aeoi_en ? '0 : grant_mask;

  always_comb begin
    isr_clr = '0;
    if (eoi_spec) isr_clr = isr_clr | (N'(1) << eoi_line);
    if (eoi_nonspec && isr_rel != EMPTY)
      isr_clr = isr_clr | (N'(1) << (isr_rel[IW-1:0] + offset_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q    <= '0;
      imr_q    <= '0;
      offset_q <= '0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (mask_we) imr_q <= mask_wdata;
      if (rot_we)
        offset_q <= rot_wdata;
      else if (grant && aeoi_en && rot_aeoi_en)
        offset_q <= int_line + IW'(1);
    end
  end

  AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_pending |-> (irr_q[int_line] && !imr_q[int_line])); // R3
  AST_NO_REQ_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec == '0) |-> !int_pending); // R4
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_pending && !aeoi_en) |=> isr_q[$past(int_line)]); // R6
  AST_AEOI_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_pending && aeoi_en && rot_aeoi_en && !rot_we)
      |=> (offset_q == $past(int_line) + IW'(1))); // R7
  AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_spec && !(ack && int_pending && !aeoi_en && int_line == eoi_line))
      |=> !isr_q[$past(eoi_line)]); // R8
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    int_pending |-> !imr_q[int_line]); // R9
endmodule

// File: tb/prio_irq_resolver_tb_top.sv
module prio_irq_resolver_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] irq_in = '0, trig_level = '0, mask_wdata = '0;
  logic mask_we = 0, sfnm_en = 0, aeoi_en = 0, rot_aeoi_en = 0, ack = 0;
  logic eoi_spec = 0, eoi_nonspec = 0, rot_we = 0;
  logic [2:0] eoi_line = '0, rot_wdata = '0;
  logic int_pending;
  logic [2:0] int_line, offset_q;
  logic [7:0] irr_q, isr_q, imr_q;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_irr = '0, m_prev = '0, m_isr = '0, m_imr = '0;
  logic [2:0] m_off = '0;

  always #5 clk = ~clk;

  prio_irq_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_level),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .sfnm_en(sfnm_en),
    .aeoi_en(aeoi_en), .rot_aeoi_en(rot_aeoi_en), .ack(ack),
    .eoi_spec(eoi_spec), .eoi_line(eoi_line), .eoi_nonspec(eoi_nonspec),
    .rot_we(rot_we), .rot_wdata(rot_wdata), .int_pending(int_pending),
    .int_line(int_line), .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q),
    .offset_q(offset_q)
  );

  // Rank of the most urgent set bit counted from base; 8 when none.
  function automatic int rank(input logic [7:0] v, input logic [2:0] base);
    for (int i = 0; i < 8; i++)
      if (v[(i + int'(base)) % 8]) return i;
    return 8;
  endfunction

  function automatic logic exp_pend();
    logic [7:0] cur = sfnm_en ? (m_isr & 8'hFB) : m_isr;
    return rank(m_irr & ~m_imr, m_off) < rank(cur, m_off);
  endfunction

  function automatic logic [2:0] exp_line();
    return 3'(rank(m_irr & ~m_imr, m_off) + int'(m_off));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1 R2 irr", irr_q, m_irr);
    chk("R6 R7 R8 isr", isr_q, m_isr);
    chk("R9 imr", imr_q, m_imr);
    chk("R7 R8 offset", offset_q, m_off);
    chk("R4 R5 R9 pending", int_pending, exp_pend());
    if (exp_pend()) chk("R3 line", int_line, exp_line());
  endtask

  // Apply current inputs for one clock edge, advance the model, then check.
  task automatic step();
    logic g, pnd;
    logic [2:0] ln;
    logic [7:0] gm, rise, n_irr, clr, n_isr;
    logic [2:0] n_off;
    int ip;
    pnd = exp_pend();
    ln = exp_line();
    g = ack && pnd;
    gm = g ? (8'h01 << ln) : 8'h00;
    rise = irq_in & ~m_prev;
    n_irr = (trig_level & irq_in) | (~trig_level & ((m_irr & ~(gm & ~trig_level)) | rise));
    ip = rank(m_isr, m_off);
    clr = eoi_spec ? (8'h01 << eoi_line) : 8'h00;
    if (eoi_nonspec && ip < 8) clr = clr | (8'h01 << 3'(ip + int'(m_off)));
    n_isr = (m_isr & ~clr) | (aeoi_en ? 8'h00 : gm);
    n_off = rot_we ? rot_wdata : ((g && aeoi_en && rot_aeoi_en) ? ln + 3'd1 : m_off);
    @(posedge clk);
    #1;
    m_irr = n_irr;
    m_prev = irq_in;
    m_isr = n_isr;
    if (mask_we) m_imr = mask_wdata;
    m_off = n_off;
    @(negedge clk);
    check_all();
  endtask

  task automatic quiet();
    ack = 0; eoi_spec = 0; eoi_nonspec = 0; rot_we = 0; mask_we = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: everything cleared after reset
    chk("R10 reset irr", irr_q, 0);
    chk("R10 reset isr", isr_q, 0);
    chk("R10 reset imr", imr_q, 0);
    chk("R10 reset offset", offset_q, 0);
    chk("R10 reset pending", int_pending, 0);

    // R2: edge line 5 rises, then falls; request stays
    irq_in = 8'h20; step();
    irq_in = 8'h00; step();
    // R1: level line 3 follows input
    trig_level = 8'h08; irq_in = 8'h08; step();
    irq_in = 8'h00; step();
    irq_in = 8'h08; step();
    // R6: grant line 3 (rank 3 beats 5); level bit stays
    ack = 1; step(); quiet();
    // R4: equal rank (line 3 in service) does not raise pending
    step();
    // R8: specific clear of line 3, then grant 3 again, nonspecific clear
    eoi_spec = 1; eoi_line = 3'd3; step(); quiet();
    ack = 1; step(); quiet();
    eoi_nonspec = 1; step(); quiet();
    // R3: rotate base to 6 so line 6/7 rank ahead of 3
    rot_we = 1; rot_wdata = 3'd6; step(); quiet();
    irq_in = 8'h88; trig_level = 8'h00; step();
    // R5: line 2 in service, request on line 2 only under nested mode
    irq_in = 8'h04; rot_we = 1; rot_wdata = 3'd0; step(); quiet();
    irq_in = 8'h00; mask_we = 1; mask_wdata = 8'hFB; step(); quiet();
    ack = 1; step(); quiet();
    mask_we = 1; mask_wdata = 8'h00; step(); quiet();
    irq_in = 8'h04; step();
    sfnm_en = 1; step();
    sfnm_en = 0; step();
    // R7: auto-EOI with rotation
    aeoi_en = 1; rot_aeoi_en = 1; irq_in = 8'h40; step();
    ack = 1; step(); quiet();
    // R9: mask every line
    mask_we = 1; mask_wdata = 8'hFF; step(); quiet();
    step();
    mask_we = 1; mask_wdata = 8'h00; step(); quiet();
    aeoi_en = 0; rot_aeoi_en = 0;

    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0) begin
        trig_level = 8'($urandom);
        sfnm_en = 1'($urandom);
        aeoi_en = ($urandom % 4) == 0;
        rot_aeoi_en = 1'($urandom);
      end
      irq_in = irq_in ^ (8'($urandom) & 8'($urandom));
      ack = ($urandom % 3) == 0;
      eoi_spec = ($urandom % 6) == 0;
      eoi_line = 3'($urandom);
      eoi_nonspec = ($urandom % 6) == 0;
      rot_we = ($urandom % 20) == 0;
      rot_wdata = 3'($urandom);
      mask_we = ($urandom % 15) == 0;
      mask_wdata = 8'($urandom) & 8'($urandom);
      step();
    end
    quiet();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule